// File: doc/BRIEF.md
# Converter serial output sequencer

This block is the digital control side of a delta-sigma converter's serial port. It runs on a system clock and steps through a power-on wait, then alternates between conversion, sleep and data output. Conversion length, power-on wait and the serial clock half-period are all counted in system clock cycles. A conversion result arrives on a parallel input and is latched when a conversion finishes. In the self-clocked timing mode the block drives the serial clock itself and shifts a 32-bit status-and-result word out on the serial data line, most significant bit first.

The timing mode depends on the level an external driver or pull-up puts on the serial clock pin. The block reads that level once at the end of the power-on wait, and again on each falling edge of chip select. With chip select held low, the block cycles on its own (continuous operation). If chip select is high during conversion and the low-going edge is delayed, that edge marks the end of sleep (autostart operation). In the externally clocked mode the block only tracks conversion and sleep state and does not drive the clock.

Top module: `adcseq_top`

## Requirements
- R1: For POR_CYC cycles after reset is released, state_o is 0 (power-on wait), sck_oe_o is 0 and sdo_o is 1. The state codes are 0 power-on wait, 1 converting, 2 sleep and 3 output.
- R2: At the end of the power-on wait the block enters conversion. ext_mode_o becomes 0 if sck_lvl_i was 1 and becomes 1 if it was 0. sck_oe_o is 1 only in the self-clocked mode.
- R3: A falling edge of cs_n_i while sck_lvl_i is 0 sets ext_mode_o the following cycle, and the mode then stays external until reset. A falling edge while sck_lvl_i is 1 leaves the mode unchanged.
- R4: A conversion lasts CONV_CYC cycles. In the self-clocked mode sck_o and sdo_o are both 1 throughout.
- R5: When a conversion ends, sck_o and sdo_o both go to 0 (sleep). With cs_n_i held low, sleep lasts exactly HALF_CYC cycles.
- R6: While cs_n_i is high, sleep continues indefinitely. Once cs_n_i is low and the minimum sleep has passed, output begins on the next cycle.
- R7: The output word, from bit 31 down to bit 0, is: 0 (end-of-conversion flag), 0 (fixed), sign_i, xrange_i, mag_i[23:0], sub_i[3:0]. Bit 31 is sent first, and each bit is valid at the corresponding sck_o rising edge.
- R8: The output lasts 63 half-periods of HALF_CYC cycles each. sck_o rises 32 times, starting on entry, and sdo_o changes only when sck_o falls.
- R9: When the last half-period ends, a new conversion starts with sck_o and sdo_o both 1. The word sent is the one latched at the end of the conversion, and input changes after that point do not affect it.
- R10: In the external mode sck_oe_o is 0 and sdo_o is 1 during conversion. After conversion the block stays in sleep with sdo_o at 0, even if cs_n_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_lvl_i | input | 1 | Serial clock pin level set by external driver or pull-up |
| sign_i | input | 1 | Result sign |
| xrange_i | input | 1 | Result out of nominal range |
| mag_i | input | 24 | Result magnitude |
| sub_i | input | 4 | Bits below the result LSB |
| sck_o | output | 1 | Driven serial clock value |
| sck_oe_o | output | 1 | Serial clock drive enable |
| sdo_o | output | 1 | Serial data out |
| state_o | output | 2 | Sequencer state code |
| ext_mode_o | output | 1 | 1 when external timing mode is selected |

## Verification
Each state change is visible one system clock after the edge that causes it. The power-on wait lasts POR_CYC cycles from the release of reset, conversion lasts CONV_CYC cycles, continuous sleep lasts HALF_CYC cycles, output lasts 63×HALF_CYC cycles, and a chip-select fall in sleep produces output one cycle later. The bench drives inputs and samples outputs on the falling clock edge. It measures each dwell by counting consecutive samples in a state and compares the count with these figures. Output bits are pushed into a queue when each word is latched, and a monitor compares them with sdo_o at every rising sck_o.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W   = 24;
    localparam int SUB_W   = 4;
    localparam int FRAME_W = 4 + RES_W + SUB_W;

    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_OUT   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             sign;
        logic             xrange;
        logic [RES_W-1:0] mag;
        logic [SUB_W-1:0] sub;
    } conv_word_t;

    // flag(0), fixed(0), sign, range, magnitude, sub-LSB bits
    function automatic logic [FRAME_W-1:0] pack_frame(input conv_word_t w);
        return {1'b0, 1'b0, w.sign, w.xrange, w.mag, w.sub};
    endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != TOP)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/adcseq_mode.sv
module adcseq_mode (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic por_done,
    input  logic cs_n_i,
    input  logic sck_lvl_i,
    output logic ext_next,
    output logic ext_q
);
    logic cs_q;
    logic cs_fall;

    assign cs_fall = cs_q & ~cs_n_i;

    always_comb begin
        if (por_done)
            ext_next = ~sck_lvl_i;
        else
            ext_next = ext_q | (active & cs_fall & ~sck_lvl_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            ext_q <= 1'b0;
        end else begin
            cs_q  <= cs_n_i;
            ext_q <= ext_next;
        end
    end
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame #(
    parameter int FW   = 32,
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [FW-1:0]   word_in,
    input  logic [PH_W-1:0] ph,
    output logic            bit_o
);
    localparam int IW = $clog2(FW);

    logic [FW-1:0] frame_q;
    logic [PH_W:0] sum;
    logic [PH_W:0] half_idx;
    logic [PH_W:0] idx;

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= '0;
        else if (load)
            frame_q <= word_in;
    end

    // A new bit appears at each odd (low) phase; the even phase that follows holds it.
    always_comb begin
        sum      = {1'b0, ph} + (PH_W+1)'(1);
        half_idx = sum >> 1;
        idx      = (PH_W+1)'(FW - 1) - half_idx;
        bit_o    = frame_q[idx[IW-1:0]];
    end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int POR_CYC  = 16,
    parameter int CONV_CYC = 64,
    parameter int HALF_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_i,
    input  logic             sck_lvl_i,
    input  logic             sign_i,
    input  logic             xrange_i,
    input  logic [RES_W-1:0] mag_i,
    input  logic [SUB_W-1:0] sub_i,
    output logic             sck_o,
    output logic             sck_oe_o,
    output logic             sdo_o,
    output logic [1:0]       state_o,
    output logic             ext_mode_o
);
    localparam int MAX_A  = (POR_CYC > CONV_CYC) ? POR_CYC : CONV_CYC;
    localparam int MAX_C  = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int PHASES = 2 * FRAME_W - 1;
    localparam int PH_W   = $clog2(PHASES + 1);

    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PHASES - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             load;
    logic             por_done;
    logic             active;
    logic             ext_next;
    logic             ext_q;
    logic             shift_bit;
    conv_word_t       word;

    assign word     = '{sign: sign_i, xrange: xrange_i, mag: mag_i, sub: sub_i};
    assign por_done = (st_q == ST_POR) && (cnt == POR_LAST);
    assign active   = (st_q != ST_POR);

    adcseq_timer #(.W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    adcseq_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .por_done  (por_done),
        .cs_n_i    (cs_n_i),
        .sck_lvl_i (sck_lvl_i),
        .ext_next  (ext_next),
        .ext_q     (ext_q)
    );

    adcseq_frame #(.FW(FRAME_W), .PH_W(PH_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .word_in (pack_frame(word)),
        .ph      (ph_q),
        .bit_o   (shift_bit)
    );

    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        cnt_clr = 1'b0;
        load    = 1'b0;
        unique case (st_q)
            ST_POR: begin
                if (por_done) begin
                    st_d    = ST_CONV;
                    cnt_clr = 1'b1;
                end
            end
            ST_CONV: begin
                if (cnt == CONV_LAST) begin
                    st_d    = ST_SLEEP;
                    cnt_clr = 1'b1;
                    load    = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!ext_next && (cnt >= HALF_LAST) && !cs_n_i) begin
                    st_d    = ST_OUT;
                    ph_d    = '0;
                    cnt_clr = 1'b1;
                end
            end
            ST_OUT: begin
                if (ext_next) begin
                    st_d    = ST_SLEEP;
                    cnt_clr = 1'b1;
                end else if (cnt == HALF_LAST) begin
                    cnt_clr = 1'b1;
                    if (ph_q == PH_LAST)
                        st_d = ST_CONV;
                    else
                        ph_d = ph_q + PH_W'(1);
                end
            end
            default: st_d = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_POR;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
        end
    end

    assign sck_oe_o   = active && !ext_q;
    assign sck_o      = (st_q == ST_OUT) ? ~ph_q[0] : (st_q != ST_SLEEP);
    assign sdo_o      = (st_q == ST_OUT) ? shift_bit : (st_q != ST_SLEEP);
    assign state_o    = st_q;
    assign ext_mode_o = ext_q;
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] state_o,
    input logic       ext_mode_o,
    input logic       sck_o,
    input logic       sck_oe_o,
    input logic       sdo_o
);
    // R1
    por_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0) |-> (!sck_oe_o && sdo_o));

    // R3
    ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode_o |=> ext_mode_o);

    // R4
    conv_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && !ext_mode_o) |-> (sck_o && sdo_o));

    // R5
    sleep_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && !ext_mode_o) |-> (!sck_o && !sdo_o));

    // R8
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && $past(state_o) == 2'd3 && sdo_o != $past(sdo_o))
            |-> (!sck_o && $past(sck_o)));

    // R10
    ext_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode_o |-> !sck_oe_o);
endmodule

bind adcseq_top adcseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .ext_mode_o (ext_mode_o),
    .sck_o      (sck_o),
    .sck_oe_o   (sck_oe_o),
    .sdo_o      (sdo_o)
);

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
    import adcseq_pkg::*;

    localparam int POR_CYC  = 16;
    localparam int CONV_CYC = 64;
    localparam int HALF_CYC = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst, cs_n, sck_lvl, sign, xr;
    logic [RES_W-1:0] mag;
    logic [SUB_W-1:0] sub;
    logic             sck_o, sck_oe, sdo;
    logic [1:0]       state;
    logic             ext;

    adcseq_top #(.POR_CYC(POR_CYC), .CONV_CYC(CONV_CYC), .HALF_CYC(HALF_CYC)) u_dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_lvl_i(sck_lvl),
        .sign_i(sign), .xrange_i(xr), .mag_i(mag), .sub_i(sub),
        .sck_o(sck_o), .sck_oe_o(sck_oe), .sdo_o(sdo),
        .state_o(state), .ext_mode_o(ext)
    );

    int checks = 0;
    int bad    = 0;
    int rises  = 0;
    logic exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // driver side of the scoreboard: expected word per R7 layout
    task automatic push_frame(input logic s, input logic x,
                              input logic [RES_W-1:0] m, input logic [SUB_W-1:0] sb);
        logic [FRAME_W-1:0] f;
        f = {1'b0, 1'b0, s, x, m, sb};
        for (int i = FRAME_W - 1; i >= 0; i--) exp_q.push_back(f[i]);
    endtask

    task automatic set_word(input logic s, input logic x,
                            input logic [RES_W-1:0] m, input logic [SUB_W-1:0] sb);
        sign = s; xr = x; mag = m; sub = sb;
    endtask

    task automatic dwell(input logic [1:0] s, output int n);
        n = 0;
        while (state == s && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // monitor side of the scoreboard
    logic       prev_sck = 1'b1;
    logic       prev_sdo = 1'b1;
    logic [1:0] prev_st  = 2'd0;
    always @(negedge clk) begin
        if (rst) begin
            prev_sck = 1'b1;
            prev_sdo = 1'b1;
            prev_st  = 2'd0;
        end else begin
            if (state == 2'd3 && sck_o && !prev_sck) begin
                rises++;
                if (exp_q.size() == 0)
                    check(1'b0, "R7", "bit with empty queue", sdo, 0);
                else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(sdo == e, "R7", "frame bit", sdo, e);
                end
            end
            if (state == 2'd3 && prev_st == 2'd3 && sdo != prev_sdo)
                check(!sck_o && prev_sck, "R8", "sdo moved without sck fall", sck_o, 0);
            prev_sck = sck_o;
            prev_sdo = sdo;
            prev_st  = state;
        end
    end

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        rst = 1'b1; cs_n = 1'b0; sck_lvl = 1'b1;
        set_word(1'b1, 1'b0, 24'hA5C30F, 4'h9);
        repeat (3) @(negedge clk);
        check(state == 2'd0 && !sck_oe && sdo, "R1", "reset state", {state, sck_oe, sdo}, 3'b001);
        rst = 1'b0;

        // continuous operation, self-clocked
        dwell(2'd0, n);
        check(n == POR_CYC, "R1", "power-on wait length", n, POR_CYC);
        check(state == 2'd1 && !ext && sck_oe, "R2", "internal mode after POR", {state, ext, sck_oe}, 4'b0101);
        check(sck_o && sdo, "R4", "conversion levels", {sck_o, sdo}, 2'b11);
        push_frame(1'b1, 1'b0, 24'hA5C30F, 4'h9);
        dwell(2'd1, n);
        check(n == CONV_CYC, "R4", "conversion length", n, CONV_CYC);
        check(!sck_o && !sdo, "R5", "sleep levels", {sck_o, sdo}, 0);
        set_word(1'b0, 1'b1, 24'h3C5A96, 4'h6);   // R9: arrives after latch
        dwell(2'd2, n);
        check(n == HALF_CYC, "R5", "continuous sleep length", n, HALF_CYC);
        rises = 0;
        dwell(2'd3, n);
        check(n == 63 * HALF_CYC, "R8", "output length", n, 63 * HALF_CYC);
        check(rises == 32, "R8", "rising edge count", rises, 32);
        check(exp_q.size() == 0, "R7", "frame fully consumed", exp_q.size(), 0);
        check(state == 2'd1 && sck_o && sdo, "R9", "new conversion after frame", {state, sck_o, sdo}, 4'b0111);

        // autostart: CS released high during conversion
        cs_n = 1'b1;
        dwell(2'd1, n);
        check(n == CONV_CYC, "R4", "second conversion length", n, CONV_CYC);
        repeat (20) @(negedge clk);
        check(state == 2'd2, "R6", "sleep held while CS high", state, 2);
        push_frame(1'b0, 1'b1, 24'h3C5A96, 4'h6);
        set_word(1'b1, 1'b1, 24'h000001, 4'hF);
        rises = 0;
        cs_n = 1'b0;
        @(negedge clk);
        check(state == 2'd3, "R6", "output one cycle after CS fall", state, 3);
        check(!ext, "R3", "CS fall with SCK high keeps mode", ext, 0);
        dwell(2'd3, n);
        check(rises == 32 && exp_q.size() == 0, "R7", "second frame complete", rises, 32);

        // switch to external mode during sleep
        cs_n = 1'b1;
        dwell(2'd1, n);
        check(state == 2'd2 && sck_oe, "R5", "sleep before switch", {state, sck_oe}, 3'b101);
        sck_lvl = 1'b0;
        cs_n = 1'b0;
        @(negedge clk);
        check(ext && !sck_oe, "R3", "CS fall with SCK low selects external", {ext, sck_oe}, 2'b10);
        repeat (20) @(negedge clk);
        check(state == 2'd2 && !sdo, "R10", "external mode stays asleep", {state, sdo}, 3'b100);
        cs_n = 1'b1; sck_lvl = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check(ext, "R3", "external mode sticky", ext, 1);

        // power-on with SCK held low
        rst = 1'b1; cs_n = 1'b1; sck_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        dwell(2'd0, n);
        check(n == POR_CYC, "R1", "second power-on wait", n, POR_CYC);
        check(ext && state == 2'd1 && !sck_oe && sdo, "R2", "external mode after POR",
              {ext, state, sck_oe, sdo}, 5'b10101);
        dwell(2'd1, n);
        check(n == CONV_CYC, "R10", "external conversion length", n, CONV_CYC);
        cs_n = 1'b0;
        repeat (30) @(negedge clk);
        check(state == 2'd2 && !sdo && !sck_oe, "R10", "external sleep persists", {state, sdo, sck_oe}, 4'b1000);
        finish_run();
    end
endmodule